// File: doc/BRIEF.md
# Subcode Q-Channel Ready Handshake

This block sits between a disc decoding pipeline and a microcontroller. The pipeline offers one Q-channel subcode word per frame period. Each word is 80 bits and comes with a flag that says whether its CRC passed. When a good word is taken, the block drives an active-low ready flag. The microcontroller then raises a read-enable line and clocks the word out, most significant bit first, on its own serial clock. The read-enable line and the serial clock are asynchronous to the block clock, so both are brought through a synchronizer before use.

The word input is a valid/ready stream with one difference from the usual contract: the source cannot stall. A frame offered while `frm_ready` is low is discarded and never held. `frm_ready` is low while a read is in progress. It is also low for the single frame slot after a read that ran past its window. Frames that fail CRC never raise ready and never replace the stored word. As a result, the gap between two ready assertions grows by one whole frame period for each frame that is bad or skipped. The data pin has a separate output enable and floats whenever read-enable is low, so the clock and data wires can carry other traffic. The frame period, the read window and the ready pulse width are cycle-count parameters.

Top module: `subq_ready_port`

## Requirements
- R1: After reset, `sq_rdy_n` is 1, `dat_oe` is 0 and `frm_ready` is 1. `dat_oe` stays 0, even with read-enable high, until the first good word has been taken.
- R2: A word offered with `frm_valid`=1 and `frm_crc_ok`=1 while `frm_ready`=1 is taken at that clock edge. `sq_rdy_n` goes to 0 in the following cycle. If no read starts, it stays 0 for exactly PULSE_CYC cycles and then returns to 1.
- R3: A word offered with `frm_crc_ok`=0 never drives `sq_rdy_n` to 0 and does not replace the stored word.
- R4: A rising edge on `mcu_ren`, after synchronization, returns `sq_rdy_n` to 1 at once, ending the ready pulse early.
- R5: While `mcu_ren` is high, `dat_o` first presents bit 79 of the stored word. Each synchronized rising edge of `mcu_sclk` then advances one bit toward bit 0.
- R6: While the synchronized `mcu_ren` is low, `dat_oe` is 0. Edges on `mcu_sclk` during that time leave the stored word unchanged.
- R7: A word offered while a read is in progress is dropped. It raises no ready and does not disturb the bits being read.
- R8: If a read ends before WINDOW_CYC cycles have passed since ready went low, the next good word one frame period later raises ready again.
- R9: If read-enable is still high when WINDOW_CYC cycles have passed since ready went low, the next offered frame is dropped even if the read has ended by then. The frame after that is accepted normally.
- R10: `frm_ready` is 0 exactly when an offered word would be dropped: during a read, or while a skip is pending from R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle frame strobe from the pipeline |
| frm_ready | output | 1 | High when an offered word would be taken |
| frm_crc_ok | input | 1 | CRC-pass flag for the offered word |
| frm_payload | input | PAYLOAD_W | Q-channel word |
| mcu_ren | input | 1 | Read enable from the microcontroller (asynchronous) |
| mcu_sclk | input | 1 | Serial clock from the microcontroller (asynchronous) |
| sq_rdy_n | output | 1 | Active-low word-ready flag |
| dat_o | output | 1 | Serial data, MSB first |
| dat_oe | output | 1 | Output enable for the data pad; 0 means high impedance |

## Verification
The bench targets three cases. The first is a slow read that ends before the next frame arrives. A design that decides on the read level at frame time, rather than at window expiry, would raise ready one frame too early. The second is a word offered in the middle of a read. A design that reloads its shift register would corrupt the bits being shifted out, or would raise a spurious ready. The third is a bad-CRC word followed by a read. A design that loads regardless of CRC would return the wrong word, and one that shifts on the serial clock while read-enable is low would return a rotated word. Random frame sequences mix good and bad CRC with no read, fast reads and slow reads. A bench model predicts the ready pulses and the skipped slots for these sequences.

// File: rtl/subq_pkg.sv
package subq_pkg;
  // What happens to a frame strobe in the cycle it is offered.
  typedef enum logic [1:0] {
    FD_NONE = 2'd0,
    FD_TAKE = 2'd1,
    FD_BADCRC = 2'd2,
    FD_BUSY = 2'd3
  } frm_dec_e;

  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/subq_sync.sv
module subq_sync #(
  parameter int N = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din[i]};
    end
    assign lvl[i]  = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/subq_timer.sv
module subq_timer #(
  parameter int unsigned LOADV = 16,
  parameter int unsigned MAXV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cancel,
  output logic done
);
  localparam int unsigned CW = subq_pkg::cnt_width(MAXV);
  localparam logic [CW-1:0] LV = CW'(LOADV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= LV;
    else if (cancel)      cnt <= '0;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));

  // R2
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (cnt == '0));
endmodule

// File: rtl/subq_shifter.sv
module subq_shifter #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         sh,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr <= '0;
    else if (ld)  sr <= din;
    else if (sh)  sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !sh) |=> $stable(sr));
endmodule

// File: rtl/subq_ctrl.sv
module subq_ctrl #(
  parameter int unsigned FRAME_CYC = 2500,
  parameter int unsigned WINDOW_CYC = 1200,
  parameter int unsigned PULSE_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_valid,
  input  logic frm_crc_ok,
  input  logic ren_lvl,
  input  logic ren_rise,
  output logic frm_ready,
  output logic take,
  output logic rdy_n,
  output logic have_word
);
  import subq_pkg::*;

  logic     pulse_done, win_done, skip_q;
  frm_dec_e dec;

  always_comb begin
    if (!frm_valid)                dec = FD_NONE;
    else if (ren_lvl || skip_q)    dec = FD_BUSY;
    else if (!frm_crc_ok)          dec = FD_BADCRC;
    else                           dec = FD_TAKE;
  end

  assign take      = (dec == FD_TAKE);
  assign frm_ready = ~ren_lvl & ~skip_q;

  subq_timer #(.LOADV(PULSE_CYC), .MAXV(FRAME_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load(take), .cancel(ren_rise), .done(pulse_done)
  );

  subq_timer #(.LOADV(WINDOW_CYC), .MAXV(FRAME_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .load(take), .cancel(1'b0), .done(win_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rdy_n <= 1'b1;
    else if (take)                   rdy_n <= 1'b0;
    else if (ren_rise || pulse_done) rdy_n <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      skip_q <= 1'b0;
    else if (win_done && ren_lvl)    skip_q <= 1'b1;
    else if (frm_valid && skip_q)    skip_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     have_word <= 1'b0;
    else if (take)  have_word <= 1'b1;
  end

  // R2
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(frm_valid && frm_crc_ok));
  // R3
  bad_crc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_crc_ok) |=> !$fell(rdy_n));
  // R4
  ren_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_rise |=> rdy_n);
  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ren_lvl) |=> !$fell(rdy_n));
  // R9
  skip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && skip_q) |=> (!$fell(rdy_n) && !skip_q));
endmodule

// File: rtl/subq_ready_port.sv
module subq_ready_port #(
  parameter int PAYLOAD_W = 80,
  parameter int unsigned FRAME_CYC = 131000,
  parameter int unsigned WINDOW_CYC = 26000,
  parameter int unsigned PULSE_CYC = 23000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_valid,
  output logic                 frm_ready,
  input  logic                 frm_crc_ok,
  input  logic [PAYLOAD_W-1:0] frm_payload,
  input  logic                 mcu_ren,
  input  logic                 mcu_sclk,
  output logic                 sq_rdy_n,
  output logic                 dat_o,
  output logic                 dat_oe
);
  localparam int NSYNC = 2;
  localparam int IDX_REN = 0;
  localparam int IDX_SCLK = 1;

  logic [NSYNC-1:0] s_lvl, s_rise;
  logic take, have_word, msb, shift;

  subq_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({mcu_sclk, mcu_ren}), .lvl(s_lvl), .rise(s_rise)
  );

  subq_ctrl #(.FRAME_CYC(FRAME_CYC), .WINDOW_CYC(WINDOW_CYC), .PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_crc_ok(frm_crc_ok),
    .ren_lvl(s_lvl[IDX_REN]), .ren_rise(s_rise[IDX_REN]), .frm_ready(frm_ready),
    .take(take), .rdy_n(sq_rdy_n), .have_word(have_word)
  );

  assign shift = s_lvl[IDX_REN] & s_rise[IDX_SCLK];

  subq_shifter #(.W(PAYLOAD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ld(take), .din(frm_payload), .sh(shift), .msb(msb)
  );

  assign dat_oe = s_lvl[IDX_REN] & have_word;
  assign dat_o  = dat_oe & msb;

  // R6
  float_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_lvl[IDX_REN] |-> !dat_oe);
  // R1
  no_word_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_word |-> (!dat_oe && sq_rdy_n));
endmodule

// File: tb/subq_ready_port_bench.sv
`timescale 1ns/100ps
module subq_ready_port_bench;
  localparam int W = 80;
  localparam int FRAME = 2500;
  localparam int WIN = 1200;
  localparam int PULSE = 300;
  localparam int HFAST = 4;
  localparam int HSLOW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0, frm_crc_ok = 1'b0, mcu_ren = 1'b0, mcu_sclk = 1'b0;
  logic [W-1:0] frm_payload = '0;
  logic frm_ready, sq_rdy_n, dat_o, dat_oe;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  bit skip_m = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  subq_ready_port #(.PAYLOAD_W(W), .FRAME_CYC(FRAME), .WINDOW_CYC(WIN), .PULSE_CYC(PULSE))
  u_subq_ready_port (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_crc_ok(frm_crc_ok), .frm_payload(frm_payload), .mcu_ren(mcu_ren),
    .mcu_sclk(mcu_sclk), .sq_rdy_n(sq_rdy_n), .dat_o(dat_o), .dat_oe(dat_oe)
  );

  function automatic bit exp_take(input bit crc, input bit skip);
    return crc && !skip;
  endfunction

  function automatic int exp_lows(input bit taken);
    return taken ? PULSE : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [W-1:0] p, input bit crc);
    @(negedge clk);
    frm_valid = 1'b1; frm_payload = p; frm_crc_ok = crc;
    @(negedge clk);
    frm_valid = 1'b0; frm_crc_ok = 1'b0;
  endtask

  task automatic do_read(input int h, output logic [W-1:0] w);
    mcu_ren = 1'b1;
    repeat (4) @(negedge clk);
    chk(sq_rdy_n == 1'b1, "R4", "ready after read start", W'(sq_rdy_n), W'(1));
    chk(dat_oe == 1'b1, "R5", "oe during read", W'(dat_oe), W'(1));
    w[W-1] = dat_o;
    for (int b = W - 2; b >= 0; b--) begin
      mcu_sclk = 1'b1;
      repeat (h) @(negedge clk);
      mcu_sclk = 1'b0;
      repeat (h) @(negedge clk);
      w[b] = dat_o;
    end
    mcu_ren = 1'b0;
    repeat (4) @(negedge clk);
    chk(dat_oe == 1'b0, "R6", "oe after read", W'(dat_oe), W'(0));
  endtask

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  // mode 0: no read, 1: fast read, 2: slow read past the window
  task automatic run_frame(input logic [W-1:0] p, input bit crc, input int mode);
    longint t0;
    bit tk;
    int lows;
    logic [W-1:0] w;
    t0 = cyc;
    chk(frm_ready == !skip_m, "R10", "frm_ready before strobe", W'(frm_ready), W'(!skip_m));
    tk = exp_take(crc, skip_m);
    skip_m = 1'b0;
    strobe(p, crc);
    if (!tk || mode == 0) begin
      lows = 0;
      while (cyc < t0 + FRAME - 2) begin
        if (!sq_rdy_n) lows++;
        @(negedge clk);
      end
      chk(lows == exp_lows(tk), !crc ? "R3" : (tk ? "R2" : "R9"), "ready low cycles",
          W'(lows), W'(exp_lows(tk)));
    end else begin
      chk(sq_rdy_n == 1'b0, "R8", "ready raised for good frame", W'(sq_rdy_n), W'(0));
      do_read(mode == 2 ? HSLOW : HFAST, w);
      chk(w == p, "R5", "word read out", w, p);
      if (mode == 2) skip_m = 1'b1;
    end
    wait_until(t0 + FRAME);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] wa, wc, wd, w;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(sq_rdy_n == 1'b1, "R1", "ready after reset", W'(sq_rdy_n), W'(1));
    chk(dat_oe == 1'b0, "R1", "oe after reset", W'(dat_oe), W'(0));
    chk(frm_ready == 1'b1, "R1", "frm_ready after reset", W'(frm_ready), W'(1));
    mcu_ren = 1'b1;
    repeat (6) @(negedge clk);
    chk(dat_oe == 1'b0, "R1", "oe with no word", W'(dat_oe), W'(0));
    mcu_ren = 1'b0;
    repeat (6) @(negedge clk);

    // R2 pulse, then R6 clock edges ignored while read-enable low, R3 bad CRC not loaded
    wa = {16'hA5C3, 32'h0123_4567, 32'h89AB_CDEF};
    run_frame(wa, 1'b1, 0);
    for (int k = 0; k < 5; k++) begin
      mcu_sclk = 1'b1; repeat (5) @(negedge clk);
      chk(dat_oe == 1'b0, "R6", "float while shared", W'(dat_oe), W'(0));
      mcu_sclk = 1'b0; repeat (5) @(negedge clk);
    end
    run_frame({W{1'b1}}, 1'b0, 0);
    do_read(HFAST, w);
    chk(w == wa, "R3", "stored word after bad frame and idle clocks", w, wa);
    repeat (20) @(negedge clk);

    // R7 word offered mid-read is dropped; slow read then forces R9 skip
    begin
      longint t0;
      wc = {16'h3C3C, 32'hDEAD_BEEF, 32'h0F0F_5A5A};
      wd = {16'hFFFF, 32'h1111_2222, 32'h3333_4444};
      t0 = cyc;
      strobe(wc, 1'b1);
      fork
        do_read(HSLOW, w);
        begin
          repeat (300) @(negedge clk);
          chk(frm_ready == 1'b0, "R10", "frm_ready during read", W'(frm_ready), W'(0));
          strobe(wd, 1'b1);
          repeat (3) @(negedge clk);
          chk(sq_rdy_n == 1'b1, "R7", "no ready for frame during read", W'(sq_rdy_n), W'(1));
        end
      join
      chk(w == wc, "R7", "read undisturbed by mid-read frame", w, wc);
      skip_m = 1'b1;
      wait_until(t0 + FRAME);
    end
    run_frame(wd, 1'b1, 0);   // skipped slot (R9)
    run_frame(wa, 1'b1, 1);   // accepted after skip, fast read (R8)
    run_frame(wd, 1'b1, 0);   // R8: follows one period after fast read

    // random frame sequences
    for (int n = 0; n < 38; n++) begin
      logic [W-1:0] p;
      p = {16'($urandom), $urandom, $urandom};
      run_frame(p, ($urandom % 5) != 0, int'($urandom % 3));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule